// File: doc/BRIEF.md
# Inbound Packet Error Checker

The checker sits on an inbound packet path that carries one word per cycle, each word tagged with a start marker, an end marker and a parity bit. It stores each packet in a small buffer. It releases the packet to the downstream consumer only once the end marker has arrived and the packet has shown no fault. A faulty packet is dropped whole by moving the write pointer back to the last committed position. Nothing of it ever reaches the output.

Every packet that ends gives the sender a completion notice, whether it was forwarded or dropped. The notice is a level that changes state once, so the sender counts completions by edge and lowers its outstanding-packet tally. Faults go out on a separate report port. The report is a one-cycle pulse with a two-bit class code. The classes are parity, framing, overflow and internal. When one packet has several faults, a fixed ranking picks the single class that is reported.

Top module: `pec_top`

## Requirements
- R1: A packet with no fault is forwarded with the same words in the same order. The first word carries out_sop and the last word carries out_eop.
- R2: A packet with any fault produces no word on the output.
- R3: done_tgl inverts exactly once for each end-marked word accepted inside a packet, one cycle after that word, whether the packet is forwarded or dropped. It inverts at no other time.
- R4: A word is a parity fault when the XOR of its data bits and in_par is 1. A packet containing one is reported with err_code 0.
- R5: Framing faults are reported with err_code 1. One kind is a start-marked word arriving inside a packet; that word is discarded whatever its end marker, and the packet is dropped at its end. The other kind is a word without a start marker arriving outside a packet; it is reported on its own, with no completion toggle.
- R6: A packet longer than DEPTH words is drained to its end marker, dropped, and reported with err_code 2. A packet of exactly DEPTH words is forwarded.
- R7: in_force_err high on any accepted word marks that word's packet, or that stray word, as an internal fault, reported with err_code 3.
- R8: A packet, or a stray word, gives exactly one report. Its class is chosen by the ranking internal > overflow > parity > framing.
- R9: err_pulse is high for one cycle, the cycle after the faulty packet's end-marked word or after the stray word. err_code is valid in that cycle.
- R10: While reset is held and right after it, out_valid, err_pulse and done_tgl are 0.
- R11: Packets sent back to back without idle cycles are each judged on their own. Good packets on either side of a dropped one are forwarded in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound word present |
| in_sop | input | 1 | Inbound word starts a packet |
| in_eop | input | 1 | Inbound word ends a packet |
| in_data | input | DATA_W | Inbound word payload |
| in_par | input | 1 | Parity bit; even parity over data plus this bit |
| in_force_err | input | 1 | Marks the current word as an internal fault |
| out_valid | output | 1 | Outbound word present |
| out_sop | output | 1 | First word of a forwarded packet |
| out_eop | output | 1 | Last word of a forwarded packet |
| out_data | output | DATA_W | Outbound word payload |
| done_tgl | output | 1 | Completion level, inverted once per finished packet |
| err_pulse | output | 1 | One-cycle fault report strobe |
| err_code | output | 2 | Fault class: 0 parity, 1 framing, 2 overflow, 3 internal |

## Verification
The bench builds the checker with DATA_W = 8 and DEPTH = 4. The shallow buffer means a five- or six-word packet crosses the overflow boundary, and a four-word packet exercises the exactly-full case in which the write pointer meets the read pointer of a packet still draining. With 8-bit words, every payload in the tests is distinct, so a reordered or duplicated word shows up in the comparison.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [1:0] {
        ERR_PAR = 2'd0,
        ERR_PKT = 2'd1,
        ERR_OVF = 2'd2,
        ERR_INT = 2'd3
    } err_code_e;

    typedef struct packed {
        logic intl;
        logic ovf;
        logic par;
        logic pkt;
    } err_flags_t;

    // Ranking: internal, then overflow, then parity, then framing.
    function automatic err_code_e pick_code(input err_flags_t f);
        if (f.intl)      return ERR_INT;
        else if (f.ovf)  return ERR_OVF;
        else if (f.par)  return ERR_PAR;
        else             return ERR_PKT;
    endfunction

endpackage

// File: rtl/pec_frame.sv
module pec_frame
    import pec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_par,
    input  logic              in_force_err,
    output logic              wr_en,
    output logic              pkt_end,
    output logic              pkt_good,
    output logic              done_tgl,
    output logic              err_pulse,
    output logic [1:0]        err_code
);

    localparam int LEN_W = $clog2(DEPTH + 1);
    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

    typedef struct packed {
        logic             in_pkt;
        logic [LEN_W-1:0] len;
        err_flags_t       flags;
        logic             done;
        logic             pulse;
        err_code_e        code;
    } frame_st_t;

    frame_st_t  q, d;
    err_flags_t f;
    logic       par_bad;

    always_comb begin
        d        = q;
        d.pulse  = 1'b0;
        wr_en    = 1'b0;
        pkt_end  = 1'b0;
        pkt_good = 1'b0;
        par_bad  = (^in_data) ^ in_par;
        f        = q.flags;
        if (in_valid) begin
            if (!q.in_pkt) begin
                f      = '0;
                f.par  = par_bad;
                f.intl = in_force_err;
                if (in_sop) begin
                    wr_en = 1'b1;
                    if (in_eop) begin
                        pkt_end  = 1'b1;
                        pkt_good = ~|f;
                        d.done   = ~q.done;
                        d.pulse  = |f;
                        d.code   = (|f) ? pick_code(f) : q.code;
                    end else begin
                        d.in_pkt = 1'b1;
                        d.flags  = f;
                        d.len    = LEN_ONE;
                    end
                end else begin
                    // word outside any packet: reported alone, never completes
                    f.pkt   = 1'b1;
                    d.pulse = 1'b1;
                    d.code  = pick_code(f);
                end
            end else begin
                f.par  = f.par | par_bad;
                f.intl = f.intl | in_force_err;
                if (in_sop) begin
                    // stray start inside a packet: word discarded
                    f.pkt   = 1'b1;
                    d.flags = f;
                end else begin
                    if (q.len == LEN_FULL) begin
                        f.ovf = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                        d.len = q.len + LEN_ONE;
                    end
                    if (in_eop) begin
                        pkt_end  = 1'b1;
                        pkt_good = ~|f;
                        d.done   = ~q.done;
                        d.pulse  = |f;
                        d.code   = (|f) ? pick_code(f) : q.code;
                        d.in_pkt = 1'b0;
                        d.flags  = '0;
                        d.len    = '0;
                    end else begin
                        d.flags = f;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_tgl  = q.done;
    assign err_pulse = q.pulse;
    assign err_code  = q.code;

    // R3: the completion level only moves after an end-marked word
    a_r3_toggle_needs_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done != $past(q.done)) |-> $past(in_valid && in_eop));

    // R9: a report strobe always follows an accepted word
    a_r9_pulse_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |-> $past(in_valid));

endmodule

// File: rtl/pec_buf.sv
module pec_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eop,
    input  logic              pkt_end,
    input  logic              pkt_good,
    input  logic              rd_en,
    output logic              have_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_CAP = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] cm;
        logic [PTR_W-1:0] rd;
    } ptr_st_t;

    ptr_st_t q, d;
    logic [DATA_W:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_next;

    always_comb begin
        d       = q;
        wr_next = wr_en ? (q.wr + PTR_ONE) : q.wr;
        d.wr    = wr_next;
        if (pkt_end) begin
            if (pkt_good) d.cm = wr_next;
            else          d.wr = q.cm;
        end
        if (rd_en) d.rd = q.rd + PTR_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[q.wr[ADDR_W-1:0]] <= {wr_eop, wr_data};
    end

    assign have_data = (q.cm != q.rd);
    assign {rd_eop, rd_data} = mem[q.rd[ADDR_W-1:0]];

    // R6: writes never run more than DEPTH words ahead of the reader
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr - q.rd) <= PTR_CAP);

endmodule

// File: rtl/pec_drain.sv
module pec_drain #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              have_data,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_eop,
    output logic              rd_en,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic [DATA_W-1:0] data;
        logic              mid;
    } drain_st_t;

    drain_st_t q, d;

    always_comb begin
        d       = q;
        d.valid = have_data;
        rd_en   = have_data;
        if (have_data) begin
            d.data = rd_data;
            d.eop  = rd_eop;
            d.sop  = ~q.mid;
            d.mid  = ~rd_eop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.valid;
    assign out_sop   = q.sop;
    assign out_eop   = q.eop;
    assign out_data  = q.data;

    // R1: a word right after a stored end marker opens a new packet
    a_r1_sop_follows_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && $past(q.valid && q.eop)) |-> q.sop);

endmodule

// File: rtl/pec_top.sv
module pec_top #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_par,
    input  logic              in_force_err,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic              done_tgl,
    output logic              err_pulse,
    output logic [1:0]        err_code
);

    logic              wr_en, pkt_end, pkt_good;
    logic              rd_en, have_data, rd_eop;
    logic [DATA_W-1:0] rd_data;

    pec_frame #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sop       (in_sop),
        .in_eop       (in_eop),
        .in_data      (in_data),
        .in_par       (in_par),
        .in_force_err (in_force_err),
        .wr_en        (wr_en),
        .pkt_end      (pkt_end),
        .pkt_good     (pkt_good),
        .done_tgl     (done_tgl),
        .err_pulse    (err_pulse),
        .err_code     (err_code)
    );

    pec_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (in_data),
        .wr_eop    (in_eop),
        .pkt_end   (pkt_end),
        .pkt_good  (pkt_good),
        .rd_en     (rd_en),
        .have_data (have_data),
        .rd_data   (rd_data),
        .rd_eop    (rd_eop)
    );

    pec_drain #(.DATA_W(DATA_W)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_data (have_data),
        .rd_data   (rd_data),
        .rd_eop    (rd_eop),
        .rd_en     (rd_en),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data)
    );

endmodule

// File: tb/test_pec_top.sv
module test_pec_top;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;
    localparam logic [4:0] NO = 5'd31;

    typedef struct packed {
        logic [4:0] len;
        logic [4:0] par_at;
        logic [4:0] frc_at;
        logic [4:0] sop_at;
        logic       fwd;
        logic       rep;
        logic [1:0] code;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{5'd1, NO,    NO,    NO,    1'b1, 1'b0, 2'd0, 4'd1}, // R1 single word
        '{5'd3, NO,    NO,    NO,    1'b1, 1'b0, 2'd0, 4'd1}, // R1
        '{5'd4, NO,    NO,    NO,    1'b1, 1'b0, 2'd0, 4'd6}, // R6 exactly full
        '{5'd3, 5'd1,  NO,    NO,    1'b0, 1'b1, 2'd0, 4'd4}, // R4
        '{5'd2, NO,    5'd0,  NO,    1'b0, 1'b1, 2'd3, 4'd7}, // R7
        '{5'd3, NO,    NO,    5'd2,  1'b0, 1'b1, 2'd1, 4'd5}, // R5 mid start
        '{5'd6, NO,    NO,    NO,    1'b0, 1'b1, 2'd2, 4'd6}, // R6 too long
        '{5'd6, 5'd1,  NO,    NO,    1'b0, 1'b1, 2'd2, 4'd8}, // R8 ovf over par
        '{5'd3, 5'd2,  NO,    5'd1,  1'b0, 1'b1, 2'd0, 4'd8}, // R8 par over pkt
        '{5'd5, NO,    5'd4,  NO,    1'b0, 1'b1, 2'd3, 4'd8}, // R8 int over ovf
        '{5'd2, 5'd1,  NO,    NO,    1'b0, 1'b1, 2'd0, 4'd4}  // R4 on end word
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_par = 1'b0, in_force_err = 1'b0;
    logic              out_valid, out_sop, out_eop, done_tgl, err_pulse;
    logic [DATA_W-1:0] out_data;
    logic [1:0]        err_code;

    int checks = 0;
    int errors = 0;

    logic [DATA_W+1:0] got_w [$];
    logic [1:0]        got_c [$];
    logic [DATA_W+1:0] exp_w [$];
    int                toggles = 0;
    logic              last_done = 1'b0;

    always #5 clk = ~clk;

    pec_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_pec_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_par(in_par),
        .in_force_err(in_force_err), .out_valid(out_valid), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data), .done_tgl(done_tgl),
        .err_pulse(err_pulse), .err_code(err_code)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) got_w.push_back({out_sop, out_eop, out_data});
            if (err_pulse) got_c.push_back(err_code);
            if (done_tgl != last_done) toggles++;
            last_done = done_tgl;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit s, input bit e, input logic [DATA_W-1:0] v,
                         input bit badp, input bit frc);
        @(negedge clk);
        in_valid = 1'b1; in_sop = s; in_eop = e; in_data = v;
        in_par = (^v) ^ badp; in_force_err = frc;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_force_err = 1'b0;
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        got_w.delete(); got_c.delete(); exp_w.delete(); toggles = 0;
    endtask

    task automatic send(input vec_t v, input int seed);
        for (int i = 0; i < int'(v.len); i++) begin
            if (5'(i) == v.sop_at) drive(1'b1, 1'b0, 8'hA5, 1'b0, 1'b0);
            drive(i == 0, i == int'(v.len) - 1, 8'(seed + i), 5'(i) == v.par_at,
                  5'(i) == v.frc_at);
            if (v.fwd) exp_w.push_back({1'(i == 0), 1'(i == int'(v.len) - 1), 8'(seed + i)});
        end
    endtask

    task automatic compare_words(input string req);
        check(got_w.size() == exp_w.size(), req, got_w.size(), exp_w.size());
        if (got_w.size() == exp_w.size())
            for (int i = 0; i < exp_w.size(); i++)
                check(got_w[i] == exp_w[i], req, int'(got_w[i]), int'(exp_w[i]));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic old;
        repeat (3) @(negedge clk);
        // R10: outputs quiet while reset is held
        check(!out_valid && !err_pulse && !done_tgl, "R10", int'({out_valid, err_pulse, done_tgl}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !err_pulse && !done_tgl, "R10", int'({out_valid, err_pulse, done_tgl}), 0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            clear_mon();
            send(VECS[k], k * 16);
            idle();
            repeat (12) @(negedge clk);
            compare_words(VECS[k].fwd ? "R1" : "R2");
            check(toggles == 1, "R3", toggles, 1);
            check(got_c.size() == (VECS[k].rep ? 1 : 0), "R9", got_c.size(), VECS[k].rep ? 1 : 0);
            if (VECS[k].rep && got_c.size() == 1)
                check(got_c[0] == VECS[k].code, $sformatf("R%0d", VECS[k].tag),
                      got_c[0], VECS[k].code);
        end

        // R3 R9 exact cycle: single-word packet with a parity fault
        clear_mon();
        old = done_tgl;
        drive(1'b1, 1'b1, 8'h3C, 1'b1, 1'b0);
        idle();
        check(done_tgl == ~old, "R3", done_tgl, ~old);
        check(err_pulse && err_code == 2'd0, "R9", int'({err_pulse, err_code}), 4);
        @(negedge clk);
        check(!err_pulse, "R9", err_pulse, 0);
        check(got_w.size() == 0, "R2", got_w.size(), 0);

        // R5: stray data word and stray end word, no completion toggle
        clear_mon();
        drive(1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 8'h12, 1'b0, 1'b0);
        idle();
        repeat (4) @(negedge clk);
        check(got_c.size() == 2, "R5", got_c.size(), 2);
        if (got_c.size() == 2) begin
            check(got_c[0] == 2'd1, "R5", got_c[0], 1);
            check(got_c[1] == 2'd1, "R5", got_c[1], 1);
        end
        check(toggles == 0, "R5", toggles, 0);
        check(got_w.size() == 0, "R5", got_w.size(), 0);

        // R8: stray word ranking (parity over framing, internal over parity)
        clear_mon();
        drive(1'b0, 1'b0, 8'h21, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 8'h22, 1'b1, 1'b1);
        idle();
        repeat (4) @(negedge clk);
        check(got_c.size() == 2, "R8", got_c.size(), 2);
        if (got_c.size() == 2) begin
            check(got_c[0] == 2'd0, "R8", got_c[0], 0);
            check(got_c[1] == 2'd3, "R8", got_c[1], 3);
        end

        // R11: good, bad, good back to back
        clear_mon();
        send('{5'd3, NO, NO, NO, 1'b1, 1'b0, 2'd0, 4'd11}, 8'h40);
        send('{5'd2, 5'd0, NO, NO, 1'b0, 1'b1, 2'd0, 4'd11}, 8'h50);
        send('{5'd4, NO, NO, NO, 1'b1, 1'b0, 2'd0, 4'd11}, 8'h60);
        idle();
        repeat (12) @(negedge clk);
        compare_words("R11");
        check(toggles == 3, "R11", toggles, 3);
        check(got_c.size() == 1, "R11", got_c.size(), 1);

        // R6 R11: two full-depth packets back to back
        clear_mon();
        send('{5'd4, NO, NO, NO, 1'b1, 1'b0, 2'd0, 4'd6}, 8'h80);
        send('{5'd4, NO, NO, NO, 1'b1, 1'b0, 2'd0, 4'd6}, 8'h90);
        idle();
        repeat (12) @(negedge clk);
        compare_words("R6");
        check(got_c.size() == 0, "R11", got_c.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule